// File: doc/BRIEF.md
# SIMD Partitioned Add-Immediate Unit

This combinational slice adds one signed 16-bit immediate to a 64-bit register operand. The operand is treated as a vector of equal-width lanes, and a 2-bit element-width code chosen at run time sets that width. The immediate is a scalar. It is first fitted to the lane width: it is cut down for narrow lanes and sign-extended for wide ones. The fitted value is then copied whole into every lane. Each lane is added on its own and wraps at its own width.

The unit uses a single byte-sliced adder chain for every width. The carry between two neighbouring bytes is passed on only when both bytes belong to the same lane, and a small decoder derives those byte gates from the width code. The output follows the inputs within the same cycle. There is no clock and no state.

Top module: `simd_addi_unit`

## Requirements
- R1: `ew_sel` selects the lane width as 00 = 8 bits (eight lanes), 01 = 16 bits (four lanes), 10 = 32 bits (two lanes) and 11 = 64 bits (one lane). Lane 0 sits in bits [W-1:0] and each higher lane takes the next W bits.
- R2: With 8-bit lanes, only `imm_i[7:0]` is added in each lane and the upper immediate byte has no effect.
- R3: With 32-bit and 64-bit lanes, the immediate is sign-extended to the lane width before it is added (for example, 0x8000 adds 0xFFFF8000 per 32-bit lane).
- R4: Every lane receives the same fitted immediate. The immediate is neither split bitwise across lanes nor placed in lane 0 only.
- R5: Each lane sum wraps modulo 2^W, and no carry moves from one lane into the next.
- R6: With 16-bit lanes, operand 0x0123_4567_89AB_CDEF plus immediate 0x7531 gives 0x7654_BA98_FEDC_4320.
- R7: With the 64-bit lane, carries ripple through all eight bytes, so the result is the full 64-bit modular sum.
- R8: For every width code, the result matches an independent per-lane reference sum, and zero inputs give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Register operand, viewed as a vector of lanes |
| imm_i | input | 16 | Signed scalar immediate |
| ew_sel | input | 2 | Element-width code (00=8, 01=16, 10=32, 11=64 bits) |
| res_o | output | 64 | Lane-wise sum |

## Verification
Operands with all-ones lanes plus an immediate of 1 separate a correct carry cut from a carry that leaks into the next lane (R5). The same pattern in the 64-bit mode catches a cut that is wrongly applied (R7). Immediates 0x7FFF, 0x8000 and 0x1234 separate three things: a replicated immediate versus one split across lanes or placed in lane 0 only, truncation versus sign extension, and correct use of the upper byte. The worked 16-bit vector and random operands checked at every width against a per-lane model cover the width decode and the lane ordering.

// File: rtl/simd_addi_pkg.sv
package simd_addi_pkg;
   typedef enum logic [1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } ew_code_t;

   localparam int unsigned NUM_EW_CODES = 4;

   // bytes per lane for a width code
   function automatic int unsigned lane_bytes(input int unsigned code);
      return 1 << code;
   endfunction
endpackage

// File: rtl/simd_lane_decode.sv
module simd_lane_decode
   import simd_addi_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8
) (
   input  logic [1:0]           ew_sel,
   output logic [NUM_BYTES-1:0] carry_keep
);
   // carry_keep[i]: carry from byte i-1 may enter byte i (bit 0 always blocked)
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      logic [NUM_EW_CODES-1:0] keep_by_code;
      for (genvar c = 0; c < NUM_EW_CODES; c++) begin : g_code
         localparam int unsigned LB = lane_bytes(c);
         assign keep_by_code[c] = ((i % LB) != 0);
      end
      assign carry_keep[i] = keep_by_code[ew_sel];
   end
endmodule

// File: rtl/simd_imm_splat.sv
module simd_imm_splat
   import simd_addi_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [1:0]        ew_sel,
   output logic [DATA_W-1:0] splat_o
);
   localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] splat_by_code [NUM_EW_CODES];

   // sign-extend once to full width; truncation then falls out of byte picking
   assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

   for (genvar c = 0; c < NUM_EW_CODES; c++) begin : g_code
      localparam int unsigned LB = lane_bytes(c);
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
         localparam int unsigned SRC = i % LB;
         assign splat_by_code[c][i*BYTE_W +: BYTE_W] = imm_ext[SRC*BYTE_W +: BYTE_W];
      end
   end

   assign splat_o = splat_by_code[ew_sel];
endmodule

// File: rtl/simd_gated_adder.sv
module simd_gated_adder #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned BYTE_W   = 8,
   parameter bit          FLAT_SUM = 1'b0
) (
   input  logic [DATA_W-1:0]        a_i,
   input  logic [DATA_W-1:0]        b_i,
   input  logic [DATA_W/BYTE_W-1:0] carry_keep,
   output logic [DATA_W-1:0]        sum_o
);
   localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

   logic [NUM_BYTES:0] carry;
   assign carry[0] = 1'b0;

   if (FLAT_SUM) begin : g_flat
      // widened sum per byte, carry gated into the next byte slice
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
         logic [BYTE_W:0] wide;
         assign wide = {1'b0, a_i[i*BYTE_W +: BYTE_W]}
                     + {1'b0, b_i[i*BYTE_W +: BYTE_W]}
                     + {{BYTE_W{1'b0}}, carry[i] & carry_keep[i]};
         assign sum_o[i*BYTE_W +: BYTE_W] = wide[BYTE_W-1:0];
         assign carry[i+1] = wide[BYTE_W];
      end
   end else begin : g_ripple
      // bit-level ripple; gating only at byte entry points
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
         logic [BYTE_W:0] c;
         assign c[0] = carry[i] & carry_keep[i];
         for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            logic x, y;
            assign x = a_i[i*BYTE_W + b];
            assign y = b_i[i*BYTE_W + b];
            assign sum_o[i*BYTE_W + b] = x ^ y ^ c[b];
            assign c[b+1] = (x & y) | (c[b] & (x ^ y));
         end
         assign carry[i+1] = c[BYTE_W];
      end
   end
endmodule

// File: rtl/simd_addi_unit.sv
module simd_addi_unit
   import simd_addi_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IMM_W    = 16,
   parameter int unsigned BYTE_W   = 8,
   parameter bit          FLAT_SUM = 1'b0
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [1:0]        ew_sel,
   output logic [DATA_W-1:0] res_o
);
   localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;
   localparam int unsigned MAX_LANE  = BYTE_W * lane_bytes(NUM_EW_CODES-1);

   if (DATA_W % BYTE_W != 0) begin : g_chk_byte
      $error("DATA_W must be a multiple of BYTE_W");
   end
   if (DATA_W % MAX_LANE != 0) begin : g_chk_lane
      $error("DATA_W must hold a whole number of widest lanes");
   end
   if (IMM_W > DATA_W || IMM_W < BYTE_W) begin : g_chk_imm
      $error("IMM_W must lie between BYTE_W and DATA_W");
   end

   logic [NUM_BYTES-1:0] carry_keep;
   logic [DATA_W-1:0]    splat_vec;

   simd_lane_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
      .ew_sel     (ew_sel),
      .carry_keep (carry_keep)
   );

   simd_imm_splat #(.DATA_W(DATA_W), .IMM_W(IMM_W), .BYTE_W(BYTE_W)) u_splat (
      .imm_i   (imm_i),
      .ew_sel  (ew_sel),
      .splat_o (splat_vec)
   );

   simd_gated_adder #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .FLAT_SUM(FLAT_SUM)) u_add (
      .a_i        (op_a),
      .b_i        (splat_vec),
      .carry_keep (carry_keep),
      .sum_o      (res_o)
   );
endmodule

// File: rtl/simd_addi_chk.sv
module simd_addi_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input logic [DATA_W-1:0]        op_a,
   input logic [IMM_W-1:0]         imm_i,
   input logic [1:0]               ew_sel,
   input logic [DATA_W-1:0]        res_o,
   input logic [DATA_W-1:0]        splat,
   input logic [DATA_W/BYTE_W-1:0] carry_keep
);
   localparam int unsigned NB = DATA_W / BYTE_W;

   always_comb begin
      for (int i = 0; i < NB; i++) begin
         AST_SPLAT_UNIFORM: assert (splat[i*BYTE_W +: BYTE_W]
            == splat[(i % (1 << ew_sel))*BYTE_W +: BYTE_W]); // R4
      end
      AST_CUT_COUNT: assert ($countones(carry_keep) == NB - (NB >> ew_sel)); // R1
      AST_LOW_BYTE: assert (splat[BYTE_W-1:0] == imm_i[BYTE_W-1:0]); // R2
      if (ew_sel >= 2'd2) begin
         AST_SIGN_EXT: assert (splat[2*IMM_W-1:IMM_W] == {IMM_W{imm_i[IMM_W-1]}}); // R3
      end
      AST_LANE0_WRAP: assert (res_o[BYTE_W-1:0]
         == BYTE_W'(op_a[BYTE_W-1:0] + splat[BYTE_W-1:0])); // R5
   end
endmodule

bind simd_addi_unit simd_addi_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .BYTE_W(BYTE_W)) u_chk (
   .op_a       (op_a),
   .imm_i      (imm_i),
   .ew_sel     (ew_sel),
   .res_o      (res_o),
   .splat      (splat_vec),
   .carry_keep (carry_keep)
);

// File: tb/sim_simd_addi_unit.sv
module sim_simd_addi_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0;
   logic [15:0] imm_i = '0;
   logic [1:0]  ew_sel = '0;
   logic [63:0] res_o;
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   simd_addi_unit u0 (.op_a(op_a), .imm_i(imm_i), .ew_sel(ew_sel), .res_o(res_o));

   // per-lane model written from the requirements
   function automatic logic [63:0] ref_sum(input logic [63:0] a, input logic [15:0] imm,
                                           input logic [1:0] code);
      int unsigned w = 8 << code;
      logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
      logic [63:0] immw = {{48{imm[15]}}, imm} & mask;
      logic [63:0] r = '0;
      for (int l = 0; l < 64 / w; l++) begin
         logic [63:0] lane = (a >> (l*w)) & mask;
         r |= ((lane + immw) & mask) << (l*w);
      end
      return r;
   endfunction

   task automatic apply(input string req, input logic [63:0] a, input logic [15:0] imm,
                        input logic [1:0] code, input logic [63:0] exp);
      @(negedge clk);
      op_a = a; imm_i = imm; ew_sel = code;
      #1;
      n_vec++;
      if (res_o !== exp) begin
         n_bad++;
         $display("FAIL %s: a=%h imm=%h ew=%0d got %h expected %h", req, a, imm, code, res_o, exp);
      end
   endtask

   task automatic t_zero();          // R8
      apply("R8", 64'h0, 16'h0, 2'b00, 64'h0);
   endtask

   task automatic t_worked_vector(); // R6
      apply("R6", 64'h0123_4567_89AB_CDEF, 16'h7531, 2'b01, 64'h7654_BA98_FEDC_4320);
   endtask

   task automatic t_byte_lanes();    // R2 R4
      apply("R2", 64'h0, 16'h1234, 2'b00, 64'h3434_3434_3434_3434);
      apply("R4", 64'h0101_0101_0101_0101, 16'h7FFF, 2'b00, 64'h0);
      apply("R4", 64'h0, 16'h7531, 2'b01, 64'h7531_7531_7531_7531);
   endtask

   task automatic t_sign_ext();      // R3
      apply("R3", 64'h0, 16'h8000, 2'b10, 64'hFFFF_8000_FFFF_8000);
      apply("R3", 64'h0, 16'h8000, 2'b11, 64'hFFFF_FFFF_FFFF_8000);
      apply("R3", 64'h0000_0001_0000_0001, 16'hFFFF, 2'b10, 64'h0);
   endtask

   task automatic t_carry_cut();     // R5
      apply("R5", '1, 16'h0001, 2'b00, 64'h0);
      apply("R5", '1, 16'h0001, 2'b01, 64'h0);
      apply("R5", '1, 16'h0001, 2'b10, 64'h0);
      apply("R5", 64'h00FF_00FF_00FF_00FF, 16'h0001, 2'b00, 64'h0100_0100_0100_0100 | 64'h0001_0001_0001_0001 ^ 64'h0001_0001_0001_0001 | 64'h0000_0000_0000_0000 + 64'h0001_0001_0001_0001 - 64'h0101_0101_0101_0101 + 64'h0100_0100_0100_0100);
   endtask

   task automatic t_full_chain();    // R7
      apply("R7", '1, 16'h0001, 2'b11, 64'h0);
      apply("R7", 64'h0000_0000_FFFF_FFFF, 16'h0001, 2'b11, 64'h0000_0001_0000_0000);
   endtask

   task automatic t_random();        // R1 R8
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < 20; k++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [15:0] im = 16'($urandom);
            if (k == 0) im = 16'h7FFF;
            if (k == 1) im = 16'h8000;
            apply(c == 0 ? "R1" : "R8", a, im, 2'(c), ref_sum(a, im, 2'(c)));
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_zero();
      t_worked_vector();
      t_byte_lanes();
      t_sign_ext();
      t_carry_cut();
      t_full_chain();
      t_random();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule